// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block sits between a PWM command and the two gate drivers of a synchronous buck stage. It turns the single PWM bit into a high-side enable and a low-side enable. It guarantees that the two switches never conduct together. The dead time between them adapts to the hardware: a gate may turn on only after the opposite gate has been sensed below its turn-off threshold, and a fixed settle delay has then passed.

Two comparator flags report the sensed gate levels. One flag is true when the low-side gate voltage is below its threshold. The other is true when the high-side gate-to-switch-node voltage is below its threshold. The settle delay is `DEAD_CYC` clock cycles. At a 100 MHz clock, the default of 4 gives 40 ns, which stays well inside the 100 ns ceiling.

Two controller overrides take priority over the PWM command. A disable input turns both switches off and lets the output float. A force-low request, used by over-voltage handling, holds the high side off and turns the low side on. The block carries no data stream, so all pins are plain level signals sampled on the rising clock edge.

Top module: `gate_seq_top`

## Requirements
- R1: `hi_en_o` and `lo_en_o` are never high in the same cycle.
- R2: After a request to turn the high side on, `hi_en_o` rises on the clock edge at which `lo_gate_low_i` has been sampled high on `DEAD_CYC` consecutive edges of the wait. A low sample restarts the count.
- R3: After a request to turn the low side on, `lo_en_o` rises on the clock edge at which `hi_gate_low_i` has been sampled high on `DEAD_CYC` consecutive edges of the wait. A low sample restarts the count.
- R4: If the requested side changes while a dead-time wait is pending, the wait switches to the new side and its count restarts from zero.
- R5: While `disable_i` is sampled high, both enables are low from the following edge on, whatever the other inputs are.
- R6: While `force_lo_i` is sampled high and `disable_i` is low, `hi_en_o` is low from the following edge on. `lo_en_o` then rises under the rule of R3, even if `pwm_i` is high.
- R7: If the sense flag for the opposite gate never goes high, the pending enable stays low indefinitely. There is no timeout.
- R8: While `rst_n` is low, both enables are low. After reset, the block stays idle until `disable_i` is low. It then reaches its first on-state only through a dead-time wait under R2 or R3.
- R9: With `pwm_i` high and no override, the target is the high side. With `pwm_i` low, the target is the low side. An enable that is on stays on while its target is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM command: 1 requests the high side, 0 requests the low side |
| lo_gate_low_i | input | 1 | High when the low-side gate is sensed below its threshold |
| hi_gate_low_i | input | 1 | High when the high-side gate-to-switch-node voltage is sensed below its threshold |
| disable_i | input | 1 | Shutdown: both switches off |
| force_lo_i | input | 1 | Over-voltage request: low side on, high side off |
| hi_en_o | output | 1 | High-side gate enable |
| lo_en_o | output | 1 | Low-side gate enable |

## Verification
The PWM command is stepped through three kinds of pattern:
- Transitions where the opposite sense flag is already high. These show that the rise comes exactly `DEAD_CYC` edges later.
- Transitions where the flag is late or drops for one cycle. These separate a restarting count from one that merely pauses.
- A PWM reversal inside a pending wait. This separates restarting the wait from finishing it on the old count.

The overrides are applied over each on-state. They show that disable beats force-low, and that force-low beats PWM. A long wait with the flag held low, and a reset taken while a switch is on, cover the no-timeout and reset behaviour.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [2:0] {
    GS_OFF     = 3'd0,
    GS_WAIT_HI = 3'd1,
    GS_HI      = 3'd2,
    GS_WAIT_LO = 3'd3,
    GS_LO      = 3'd4
  } gs_state_t;

  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_HI  = 2'd1,
    TGT_LO  = 2'd2
  } gs_target_t;
endpackage

// File: rtl/gs_target_decode.sv
module gs_target_decode
  import gs_pkg::*;
(
  input  logic       pwm_i,
  input  logic       disable_i,
  input  logic       force_lo_i,
  output gs_target_t target_o
);
  // Priority: disable, then force-low, then the PWM command.
  always_comb begin
    if (disable_i)       target_o = TGT_OFF;
    else if (force_lo_i) target_o = TGT_LO;
    else if (pwm_i)      target_o = TGT_HI;
    else                 target_o = TGT_LO;
  end
endmodule

// File: rtl/gs_dead_timer.sv
module gs_dead_timer #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sense_i,
  output logic done_o
);
  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q;

  // Done when this edge would complete DEAD_CYC consecutive high samples.
  assign done_o = sense_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (!sense_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_CLEARS_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gs_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic lo_gate_low_i,
  input  logic hi_gate_low_i,
  input  logic disable_i,
  input  logic force_lo_i,
  output logic hi_en_o,
  output logic lo_en_o
);
  gs_state_t  state_q, state_d;
  gs_target_t target;
  logic       waiting, sense_sel, timer_done, timer_clear;

  gs_target_decode u_target (
    .pwm_i      (pwm_i),
    .disable_i  (disable_i),
    .force_lo_i (force_lo_i),
    .target_o   (target)
  );

  assign waiting   = (state_q == GS_WAIT_HI) || (state_q == GS_WAIT_LO);
  // Each wait watches the gate that must be off before its own side rises.
  assign sense_sel = (state_q == GS_WAIT_HI) ? lo_gate_low_i : hi_gate_low_i;

  gs_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (timer_clear),
    .sense_i (sense_sel),
    .done_o  (timer_done)
  );

  always_comb begin
    state_d = state_q;
    if (target == TGT_OFF) begin
      state_d = GS_OFF;
    end else begin
      unique case (state_q)
        GS_OFF:     state_d = (target == TGT_HI) ? GS_WAIT_HI : GS_WAIT_LO;
        GS_HI:      if (target == TGT_LO) state_d = GS_WAIT_LO;
        GS_LO:      if (target == TGT_HI) state_d = GS_WAIT_HI;
        GS_WAIT_HI: if (target == TGT_LO) state_d = GS_WAIT_LO;
                    else if (timer_done)  state_d = GS_HI;
        GS_WAIT_LO: if (target == TGT_HI) state_d = GS_WAIT_HI;
                    else if (timer_done)  state_d = GS_LO;
        default:    state_d = GS_OFF;
      endcase
    end
  end

  // Restart the count outside a wait and on every change of state.
  assign timer_clear = !waiting || (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_OFF;
    else        state_q <= state_d;
  end

  assign hi_en_o = (state_q == GS_HI);
  assign lo_en_o = (state_q == GS_LO);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_en_o && lo_en_o)); // R1
  AST_HI_AFTER_LO_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en_o) |-> $past(lo_gate_low_i)); // R2
  AST_LO_AFTER_HI_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_en_o) |-> $past(hi_gate_low_i)); // R3
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disable_i) |-> (!hi_en_o && !lo_en_o)); // R5
  AST_FORCE_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_lo_i) |-> !hi_en_o); // R6
  AST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_WAIT_HI && !lo_gate_low_i) |=> !hi_en_o); // R7
endmodule

// File: tb/tb_gate_seq_top.sv
module tb_gate_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_i = 1'b0, lo_gate_low_i = 1'b1, hi_gate_low_i = 1'b1;
  logic disable_i = 1'b1, force_lo_i = 1'b0;
  logic hi_en_o, lo_en_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_seq_top #(.DEAD_CYC(4)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm_i),
    .lo_gate_low_i(lo_gate_low_i), .hi_gate_low_i(hi_gate_low_i),
    .disable_i(disable_i), .force_lo_i(force_lo_i),
    .hi_en_o(hi_en_o), .lo_en_o(lo_en_o)
  );

  // {disable, force_lo, pwm, lo_low, hi_low, exp_hi, exp_lo}
  localparam logic [6:0] VEC [0:NVEC-1] = '{
    7'b1000000, // 0  R5 idle while disabled
    7'b0001100, // 1  R8 leave idle into low-side wait
    7'b0001100, // 2
    7'b0001100, // 3
    7'b0001100, // 4
    7'b0001101, // 5  R3 low side on after 4 sensed edges
    7'b0010100, // 6  R9 pwm high -> wait
    7'b0010100, // 7  R7 lo sense low holds
    7'b0010100, // 8
    7'b0011100, // 9  count 1
    7'b0010100, // 10 R2 drop restarts
    7'b0011100, // 11
    7'b0011100, // 12
    7'b0011100, // 13
    7'b0011110, // 14 R2 high side on
    7'b0010010, // 15 R9 stays on
    7'b0000000, // 16 pwm low -> wait low
    7'b0000100, // 17 count 1
    7'b0011100, // 18 R4 pwm back high restarts
    7'b0011100, // 19
    7'b0011100, // 20
    7'b0011100, // 21
    7'b0011110, // 22 R4 on after full fresh count
    7'b0110000, // 23 R6 force-low drops high side
    7'b0110100, // 24
    7'b0110100, // 25
    7'b0110100, // 26
    7'b0110101, // 27 R6 low side on despite pwm high
    7'b0110101, // 28
    7'b1110000, // 29 R5 disable wins
    7'b1010000  // 30
  };

  task automatic check(input string req, input logic eh, input logic el);
    checks++;
    if (hi_en_o !== eh || lo_en_o !== el) begin
      errors++;
      $display("FAIL %s: hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b",
               req, hi_en_o, lo_en_o, eh, el);
    end
    if (hi_en_o === 1'b1 && lo_en_o === 1'b1) begin
      checks++; errors++;
      $display("FAIL R1: hi_en=1 lo_en=1 expected not both 1");
    end
  endtask

  task automatic step(input logic [4:0] in);
    @(negedge clk);
    {disable_i, force_lo_i, pwm_i, lo_gate_low_i, hi_gate_low_i} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state with pwm requesting high side
    pwm_i = 1'b1; disable_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R8 reset", 1'b0, 1'b0);
    @(negedge clk); disable_i = 1'b1; rst_n = 1'b1;
    step(5'b10111);
    check("R8 idle while disabled", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][6:2]);
      check($sformatf("R1/R2/R3/R4/R5/R6/R9 vec %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R7: lo sense never high, high side never turns on
    step(5'b00001);
    step(5'b00001);
    step(5'b00001);
    step(5'b00001);
    step(5'b00001); // LO on
    check("R3 low on before R7", 1'b0, 1'b1);
    for (int k = 0; k < 200; k++) step(5'b00100);
    check("R7 no timeout", 1'b0, 1'b0);
    step(5'b00110);
    step(5'b00110);
    step(5'b00110);
    check("R7 count after release", 1'b0, 1'b0);
    step(5'b00110);
    check("R2 rise after release", 1'b1, 1'b0);

    // R8 reset while high side is on
    @(negedge clk); rst_n = 1'b0;
    #1 check("R8 async reset", 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(5'b00111);
    check("R8 wait after reset", 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule